// File: doc/BRIEF.md
# Soft-Decision Branch Metric Unit

This block sits in front of a rate-1/2 add-compare-select array in a convolutional decoder. For each decoded bit it takes one pair of soft symbols, one from the first generator and one from the second, plus an erasure flag for each. Both symbols are placed on one unsigned confidence scale, and the block then produces four branch metrics. There is one metric for each hypothesised code pair: 00, 01, 10 and 11.

Two soft-code formats are accepted: offset binary and offset signed-magnitude. A run-time input selects between them. A second input reverses a transmitter that inverts the second-generator symbol. A symbol marked as erased (punctured) contributes nothing to any metric. The results are registered. They appear one clock after the input strobe, and they hold while no new pair is presented.

Top module: `bmu_branch_metric`

## Requirements
- R1: With `fmt_offbin` = 1, the confidence of a symbol equals its code value. Code 7 is the strongest "1" and code 0 is the strongest "0".
- R2: With `fmt_offbin` = 0, the codes 111, 110, 101, 100, 000, 001, 010, 011 map to confidences 7, 6, 5, 4, 3, 2, 1, 0 in that order.
- R3: For confidence c, the distance to a hypothesised 1 is 7−c and the distance to a hypothesised 0 is c. Metric `bmXY` is the distance of G1 to bit X plus the distance of G2 to bit Y.
- R4: With `g2_invert` = 1, the G2 confidence c is replaced by 7−c before distances are formed, in both formats. G1 is unaffected.
- R5: An erased symbol adds 0 to all four metrics. When both symbols are erased, every metric is 0.
- R6: Hard-decision input works as follows. Signed-magnitude format is selected, only the top bit of each symbol carries data, and the lower bits are held at 1. A symbol at 1 then gives distance 0 to hypothesis 1 and distance 7 to hypothesis 0; a symbol at 0 gives the reverse.
- R7: `out_valid` equals `in_valid` delayed by one clock. The metrics for a pair appear in the same cycle that `out_valid` is asserted for it.
- R8: While `in_valid` is low, the symbol, erasure and mode inputs have no effect, and the metric outputs keep their last values.
- R9: While `rst_n` is low, `out_valid` and all four metrics are 0.
- R10: With neither symbol erased, bm00 + bm11 = 14 and bm01 + bm10 = 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A symbol pair is present this cycle |
| g1_sym | input | 3 | First-generator soft symbol |
| g2_sym | input | 3 | Second-generator soft symbol |
| g1_erase | input | 1 | First-generator symbol is punctured |
| g2_erase | input | 1 | Second-generator symbol is punctured |
| fmt_offbin | input | 1 | 1 = offset binary, 0 = offset signed-magnitude |
| g2_invert | input | 1 | Invert the G2 confidence (descramble) |
| out_valid | output | 1 | Metrics are fresh this cycle |
| bm00 | output | 4 | Metric for hypothesis G1=0, G2=0 |
| bm01 | output | 4 | Metric for hypothesis G1=0, G2=1 |
| bm10 | output | 4 | Metric for hypothesis G1=1, G2=0 |
| bm11 | output | 4 | Metric for hypothesis G1=1, G2=1 |

## Verification
The bench sweeps every code pair under both formats, both descramble settings and all four erasure combinations.

- The signed-magnitude fold point between 100 and 000 is the classic trap. A design that treated the format as plain two's complement, or forgot to flip the lower bits, would give wrong metrics for all codes with the top bit clear.
- Descrambling is checked in signed-magnitude mode, where bitwise inversion of the raw code differs from 7−c. A design that inverted bits before mapping would miss there.
- A design that inverted G1 instead of G2 would swap the wrong metric pairs.
- Erasure cases catch a design that zeroes only one hypothesis's distance or lets an erased symbol through.
- Idle cycles with changing inputs catch outputs that follow the inputs without the strobe.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
   typedef enum logic {
      FMT_SIGNMAG = 1'b0,
      FMT_OFFBIN  = 1'b1
   } soft_fmt_e;

   localparam int unsigned NUM_SYMS = 2;
   localparam int unsigned NUM_HYP  = 4;
endpackage

// File: rtl/bmu_conf_map.sv
module bmu_conf_map #(
   parameter int unsigned SYM_W       = 3,
   parameter bit          HAS_SIGNMAG = 1'b1
) (
   input  logic [SYM_W-1:0] code,
   input  logic             fmt_offbin,
   output logic [SYM_W-1:0] conf
);
   import bmu_pkg::*;

   generate
      if (SYM_W < 2) begin : g_bad_width
         $error("bmu_conf_map: SYM_W must be at least 2");
      end

      if (HAS_SIGNMAG) begin : g_both_fmt
         soft_fmt_e fmt;
         assign fmt = soft_fmt_e'(fmt_offbin);
         always_comb begin
            if (fmt == FMT_OFFBIN || code[SYM_W-1])
               conf = code;
            else
               conf = {1'b0, ~code[SYM_W-2:0]};
         end
      end else begin : g_offbin_only
         logic unused_fmt;
         assign unused_fmt = fmt_offbin;
         assign conf       = code;
      end
   endgenerate
endmodule

// File: rtl/bmu_sym_dist.sv
module bmu_sym_dist #(
   parameter int unsigned SYM_W = 3
) (
   input  logic [SYM_W-1:0] conf,
   input  logic             invert,
   input  logic             erase,
   output logic [SYM_W-1:0] dist_one,
   output logic [SYM_W-1:0] dist_zero
);
   localparam logic [SYM_W-1:0] CONF_MAX = '1;

   logic [SYM_W-1:0] conf_eff;

   always_comb begin
      conf_eff = invert ? (CONF_MAX - conf) : conf;
      if (erase) begin
         dist_one  = '0;
         dist_zero = '0;
      end else begin
         dist_one  = CONF_MAX - conf_eff;
         dist_zero = conf_eff;
      end
   end
endmodule

// File: rtl/bmu_branch_metric.sv
module bmu_branch_metric #(
   parameter int unsigned SYM_W       = 3,
   parameter bit          HAS_SIGNMAG = 1'b1,
   localparam int unsigned MET_W      = SYM_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [SYM_W-1:0] g1_sym,
   input  logic [SYM_W-1:0] g2_sym,
   input  logic             g1_erase,
   input  logic             g2_erase,
   input  logic             fmt_offbin,
   input  logic             g2_invert,
   output logic             out_valid,
   output logic [MET_W-1:0] bm00,
   output logic [MET_W-1:0] bm01,
   output logic [MET_W-1:0] bm10,
   output logic [MET_W-1:0] bm11
);
   import bmu_pkg::*;

   logic [SYM_W-1:0] sym_in  [NUM_SYMS];
   logic             sym_era [NUM_SYMS];
   logic             sym_inv [NUM_SYMS];
   logic [SYM_W-1:0] d_one   [NUM_SYMS];
   logic [SYM_W-1:0] d_zero  [NUM_SYMS];
   logic [MET_W-1:0] met_nxt [NUM_HYP];
   logic [MET_W-1:0] met_q   [NUM_HYP];

   assign sym_in[0]  = g1_sym;
   assign sym_in[1]  = g2_sym;
   assign sym_era[0] = g1_erase;
   assign sym_era[1] = g2_erase;
   assign sym_inv[0] = 1'b0;
   assign sym_inv[1] = g2_invert;

   generate
      for (genvar s = 0; s < NUM_SYMS; s++) begin : g_sym
         logic [SYM_W-1:0] conf;
         bmu_conf_map #(.SYM_W(SYM_W), .HAS_SIGNMAG(HAS_SIGNMAG)) u_map (
            .code       (sym_in[s]),
            .fmt_offbin (fmt_offbin),
            .conf       (conf)
         );
         bmu_sym_dist #(.SYM_W(SYM_W)) u_dist (
            .conf      (conf),
            .invert    (sym_inv[s]),
            .erase     (sym_era[s]),
            .dist_one  (d_one[s]),
            .dist_zero (d_zero[s])
         );
      end

      // hypothesis index h = {G1 bit, G2 bit}
      for (genvar h = 0; h < NUM_HYP; h++) begin : g_hyp
         logic [SYM_W-1:0] p1, p2;
         assign p1 = h[1] ? d_one[0] : d_zero[0];
         assign p2 = h[0] ? d_one[1] : d_zero[1];
         assign met_nxt[h] = {1'b0, p1} + {1'b0, p2};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               met_q[h] <= '0;
            else if (in_valid)
               met_q[h] <= met_nxt[h];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         out_valid <= 1'b0;
      else
         out_valid <= in_valid;
   end

   assign bm00 = met_q[0];
   assign bm01 = met_q[1];
   assign bm10 = met_q[2];
   assign bm11 = met_q[3];
endmodule

// File: rtl/bmu_branch_metric_chk.sv
module bmu_branch_metric_chk #(
   parameter int unsigned SYM_W = 3,
   localparam int unsigned MET_W = SYM_W + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             g1_erase,
   input logic             g2_erase,
   input logic             out_valid,
   input logic [MET_W-1:0] bm00,
   input logic [MET_W-1:0] bm01,
   input logic [MET_W-1:0] bm10,
   input logic [MET_W-1:0] bm11
);
   localparam logic [MET_W:0] SUM_FULL = (MET_W+1)'(2 * ((1 << SYM_W) - 1));
   localparam logic [MET_W-1:0] MET_TOP = (MET_W)'(2 * ((1 << SYM_W) - 1));

   assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(bm00) && $stable(bm01) && $stable(bm10) && $stable(bm11)));

   assert_both_erased_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && g1_erase && g2_erase) |=> (bm00 == '0 && bm01 == '0 && bm10 == '0 && bm11 == '0));

   assert_complement_sum_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !g1_erase && !g2_erase) |=>
         (({1'b0, bm00} + {1'b0, bm11}) == SUM_FULL && ({1'b0, bm01} + {1'b0, bm10}) == SUM_FULL));

   always @(posedge clk) begin
      if (rst_n) begin
         assert_metric_bound_R3: assert (bm00 <= MET_TOP && bm01 <= MET_TOP && bm10 <= MET_TOP && bm11 <= MET_TOP);
      end
   end
endmodule

bind bmu_branch_metric bmu_branch_metric_chk #(.SYM_W(SYM_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .g1_erase  (g1_erase),
   .g2_erase  (g2_erase),
   .out_valid (out_valid),
   .bm00      (bm00),
   .bm01      (bm01),
   .bm10      (bm10),
   .bm11      (bm11)
);

// File: tb/sim_bmu_branch_metric.sv
module sim_bmu_branch_metric;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [2:0] g1_sym = '0;
   logic [2:0] g2_sym = '0;
   logic       g1_erase = 1'b0;
   logic       g2_erase = 1'b0;
   logic       fmt_offbin = 1'b0;
   logic       g2_invert = 1'b0;
   logic       out_valid;
   logic [3:0] bm00, bm01, bm10, bm11;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [3:0] m00, m01, m10, m11;
      bit         erased;
      string      req;
   } exp_t;

   exp_t exp_q[$];
   exp_t last_exp;

   always #10 clk = ~clk;

   bmu_branch_metric u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .g1_sym(g1_sym), .g2_sym(g2_sym), .g1_erase(g1_erase), .g2_erase(g2_erase),
      .fmt_offbin(fmt_offbin), .g2_invert(g2_invert),
      .out_valid(out_valid), .bm00(bm00), .bm01(bm01), .bm10(bm10), .bm11(bm11)
   );

   function automatic int conf_of(input logic [2:0] code, input logic offbin);
      logic [2:0] sm_order [8] = '{3'b111, 3'b110, 3'b101, 3'b100,
                                   3'b000, 3'b001, 3'b010, 3'b011};
      if (offbin) return int'(code);              // R1
      for (int i = 0; i < 8; i++)                 // R2
         if (sm_order[i] == code) return 7 - i;
      return -1;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send(input logic [2:0] a, input logic [2:0] b, input logic ea,
                       input logic eb, input logic fo, input logic inv, input string req);
      exp_t e;
      int c1, c2, d1o, d1z, d2o, d2z;
      c1 = conf_of(a, fo);
      c2 = conf_of(b, fo);
      if (inv) c2 = 7 - c2;                       // R4
      d1o = ea ? 0 : 7 - c1;  d1z = ea ? 0 : c1;  // R3, R5
      d2o = eb ? 0 : 7 - c2;  d2z = eb ? 0 : c2;
      e.m00 = 4'(d1z + d2z);
      e.m01 = 4'(d1z + d2o);
      e.m10 = 4'(d1o + d2z);
      e.m11 = 4'(d1o + d2o);
      e.erased = ea | eb;
      e.req = req;
      @(negedge clk);
      g1_sym = a; g2_sym = b; g1_erase = ea; g2_erase = eb;
      fmt_offbin = fo; g2_invert = inv; in_valid = 1'b1;
      exp_q.push_back(e);
      last_exp = e;
   endtask

   // monitor / scoreboard
   always @(posedge clk) begin
      #1;
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            check("R7 unexpected out_valid", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.req, " bm00"}, int'(bm00), int'(e.m00));
            check({e.req, " bm01"}, int'(bm01), int'(e.m01));
            check({e.req, " bm10"}, int'(bm10), int'(e.m10));
            check({e.req, " bm11"}, int'(bm11), int'(e.m11));
            if (!e.erased) begin
               check("R10 sum 00+11", int'(bm00) + int'(bm11), 14);
               check("R10 sum 01+10", int'(bm01) + int'(bm10), 14);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9 out_valid", int'(out_valid), 0);
      check("R9 bm00", int'(bm00), 0);
      check("R9 bm11", int'(bm11), 0);
      check("R9 bm01+bm10", int'(bm01) + int'(bm10), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7 idle after reset", int'(out_valid), 0);

      // R6: hard-decision corners
      send(3'b111, 3'b111, 0, 0, 0, 0, "R6 hard 1,1");
      send(3'b011, 3'b011, 0, 0, 0, 0, "R6 hard 0,0");
      send(3'b111, 3'b011, 0, 0, 0, 0, "R6 hard 1,0");
      send(3'b011, 3'b111, 0, 0, 0, 0, "R6 hard 0,1");
      // R2 fold point, R4 descramble in signed-magnitude
      send(3'b100, 3'b000, 0, 0, 0, 0, "R2 fold");
      send(3'b000, 3'b111, 0, 0, 0, 1, "R4 signmag invert");
      send(3'b101, 3'b010, 0, 0, 1, 1, "R4 offbin invert");

      // exhaustive sweep
      for (int f = 0; f < 2; f++)
         for (int iv = 0; iv < 2; iv++)
            for (int er = 0; er < 4; er++)
               for (int a = 0; a < 8; a++)
                  for (int b = 0; b < 8; b++)
                     send(3'(a), 3'(b), er[1], er[0], f[0], iv[0],
                          er != 0 ? "R5 erase" : iv != 0 ? "R4 invert" :
                          f != 0 ? "R1 R3 offbin" : "R2 R3 signmag");

      // R8: inputs change while strobe low, outputs must hold
      @(negedge clk);
      in_valid = 1'b0;
      g1_sym = ~g1_sym; g2_sym = ~g2_sym; g1_erase = 1'b0; g2_erase = 1'b0;
      fmt_offbin = ~fmt_offbin; g2_invert = ~g2_invert;
      repeat (3) @(negedge clk);
      check("R7 out_valid low", int'(out_valid), 0);
      check("R8 hold bm00", int'(bm00), int'(last_exp.m00));
      check("R8 hold bm01", int'(bm01), int'(last_exp.m01));
      check("R8 hold bm10", int'(bm10), int'(last_exp.m10));
      check("R8 hold bm11", int'(bm11), int'(last_exp.m11));
      check("R7 queue drained", exp_q.size(), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule